// File: doc/BRIEF.md
# Prescaled Free-Running Timer with Overflow Interrupt

This block is a 16-bit up-counter that advances on a divided version of a one-cycle E-clock enable strobe. A two-bit prescale code picks the divide ratio. When the count rolls over from its all-ones value back to zero, a sticky overflow flag is raised. While a local interrupt enable is also set, an interrupt request is driven.

Software sees three things through a small byte-wide register port: the counter, a mask register and a flag register. The counter is read-only. The mask register holds the interrupt enable and the prescale code. The flag register holds the overflow flag, which is cleared by writing a one to it. The prescale code can be set once only, and only early after reset, so that the timebase cannot be disturbed later by runaway code.

Top module: `tmr_free_run`

## Requirements
- R1: After reset the count is 0x0000, the overflow flag is 0, the interrupt enable is 0, the prescale code is 00, and irq_o is low.
- R2: The count increases by one every N pulses of eclk_en_i. N is 1, 4, 8 or 16 for prescale codes 00, 01, 10 and 11. The first increment after reset lands on the Nth pulse.
- R3: Writes to address 2 (count high byte) and address 3 (count low byte) do not change the count.
- R4: When the count steps from 0xFFFF to 0x0000, the overflow flag is set. The flag reads at bit 7 of address 1.
- R5: Writing address 1 with bit 7 set clears the overflow flag. Writing 0 to bit 7 leaves the flag unchanged, whatever the other bits hold. A write never sets the flag.
- R6: If a rollover and a clearing write happen in the same cycle, the flag ends up set.
- R7: irq_o is high exactly while both the overflow flag and the interrupt enable are 1.
- R8: The mask register is at address 0, with the prescale code in bits 1:0. A new prescale code takes effect only on the first write to address 0, and only if that write comes while fewer than 64 eclk_en_i pulses have occurred since reset. Every later write leaves the code unchanged.
- R9: The interrupt enable, at bit 7 of address 0, can be written at any time, including after the prescale code is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eclk_en_i | input | 1 | E-clock enable strobe, one cycle per E-clock |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 mask, 1 flag, 2 count high, 3 count low |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| count_o | output | 16 | Current count value |
| irq_o | output | 1 | Overflow interrupt request, level |

## Verification
The hardest case to reach is a rollover that lands in the same cycle as a write that clears the flag. To set it up, the bench runs the counter at divide-by-1 until it wraps once, which leaves the flag set. It then runs the counter up to 0xFFFF again and stops the strobe there. Finally it raises the strobe and the clearing write together for exactly one cycle. The edges of the write-once window are covered by separate reset runs: one writes after 63 strobes, one after 64 strobes, and one makes a second write after an accepted first write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAG   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT_HI = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT_LO = 2'd3;

  typedef enum logic [1:0] {
    PSC_DIV1  = 2'b00,
    PSC_DIV4  = 2'b01,
    PSC_DIV8  = 2'b10,
    PSC_DIV16 = 2'b11
  } psc_code_e;

  // log2 of the divide ratio for each code
  function automatic int unsigned psc_shift(input psc_code_e code);
    case (code)
      PSC_DIV1:  return 0;
      PSC_DIV4:  return 2;
      PSC_DIV8:  return 3;
      default:   return 4;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int unsigned PSC_W = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      eclk_en_i,
  input  psc_code_e code_i,
  output logic      tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PSC_W; i++) begin
      if (i < int'(psc_shift(code_i))) mask[i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        psc_q <= '0;
    else if (eclk_en_i) psc_q <= psc_q + 1'b1;
  end

  assign tick_o = eclk_en_i && ((psc_q & mask) == mask);

  // R2
  tick_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> eclk_en_i);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && (&cnt_q);

  // R2
  hold_without_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  // R2
  step_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + 1'b1);
  // R4
  wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == '0);
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int unsigned WIN_LEN = 64
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      eclk_en_i,
  input  logic      mask_wr_i,
  input  logic      toi_wdata_i,
  input  logic [1:0] psc_wdata_i,
  output logic      toi_o,
  output psc_code_e code_o
);
  localparam int unsigned WIN_W = $clog2(WIN_LEN + 1);

  logic [WIN_W-1:0] win_q;
  logic             locked_q;
  logic             win_open;
  psc_code_e        code_q;
  logic             toi_q;

  assign win_open = win_q < WIN_W'(WIN_LEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     win_q <= '0;
    else if (eclk_en_i && win_open)  win_q <= win_q + 1'b1;
  end

  // first mask write inside the window takes the code and closes it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= PSC_DIV1;
      locked_q <= 1'b0;
    end else if (mask_wr_i && win_open && !locked_q) begin
      code_q   <= psc_code_e'(psc_wdata_i);
      locked_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        toi_q <= 1'b0;
    else if (mask_wr_i) toi_q <= toi_wdata_i;
  end

  assign toi_o  = toi_q;
  assign code_o = code_q;

  // R8
  code_frozen_after_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(code_q));
  // R8
  code_frozen_after_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_open |=> $stable(code_q));
  // R9
  toi_follows_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr_i |=> toi_q == $past(toi_wdata_i));
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic clr_i,
  output logic tof_o
);
  logic tof_q;

  // hardware set has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tof_q <= 1'b0;
    else if (wrap_i) tof_q <= 1'b1;
    else if (clr_i)  tof_q <= 1'b0;
  end

  assign tof_o = tof_q;

  // R4
  // R6
  set_on_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> tof_q);
  // R5
  clear_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wrap_i) |=> !tof_q);
  // R5
  no_soft_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tof_q && !wrap_i) |=> !tof_q);
endmodule

// File: rtl/tmr_free_run.sv
module tmr_free_run
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned PSC_W   = 4,
  parameter int unsigned WIN_LEN = 64,
  parameter int unsigned TOF_BIT = 7,
  parameter int unsigned TOI_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eclk_en_i,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o
);
  logic      tick;
  logic      wrap;
  logic      tof;
  logic      toi;
  logic      mask_wr;
  logic      flag_clr;
  psc_code_e code;
  logic [CNT_W-1:0] cnt;

  assign mask_wr  = wr_en_i && (addr_i == ADDR_MASK);
  assign flag_clr = wr_en_i && (addr_i == ADDR_FLAG) && wdata_i[TOF_BIT];

  tmr_ctrl #(.WIN_LEN(WIN_LEN)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eclk_en_i   (eclk_en_i),
    .mask_wr_i   (mask_wr),
    .toi_wdata_i (wdata_i[TOI_BIT]),
    .psc_wdata_i (wdata_i[1:0]),
    .toi_o       (toi),
    .code_o      (code)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .eclk_en_i (eclk_en_i),
    .code_i    (code),
    .tick_o    (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  tmr_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wrap_i (wrap),
    .clr_i  (flag_clr),
    .tof_o  (tof)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_MASK: begin
        rdata_o[TOI_BIT] = toi;
        rdata_o[1:0]     = code;
      end
      ADDR_FLAG:   rdata_o[TOF_BIT] = tof;
      ADDR_CNT_HI: rdata_o = cnt[CNT_W-1 -: DATA_W];
      default:     rdata_o = cnt[DATA_W-1:0];
    endcase
  end

  assign count_o = cnt;
  assign irq_o   = tof && toi;

  // R7
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (toi && tof));
  // R3
  count_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[1] && !tick) |=> $stable(count_o));
endmodule

// File: tb/sim_tmr_free_run.sv
module sim_tmr_free_run;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        eclk_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [15:0] count_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk_i = ~clk_i;

  tmr_free_run u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .eclk_en_i(eclk_en_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .count_o(count_o),
    .irq_o(irq_o)
  );

  // R2 vectors: prescale code, strobe pulses, expected count
  localparam int NV = 8;
  localparam int VEC_PR [NV] = '{0, 0, 1, 1, 2, 2, 3, 3};
  localparam int VEC_N  [NV] = '{1, 5, 3, 8, 15, 16, 15, 33};
  localparam int VEC_EXP[NV] = '{1, 5, 0, 2, 1, 2, 0, 2};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; eclk_en_i = 1'b0; wr_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic pulse(input int n);
    @(negedge clk_i);
    eclk_en_i = 1'b1;
    repeat (n) @(negedge clk_i);
    eclk_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    do_reset();
    // R1
    check("R1 count", count_o, 0);
    check("R1 irq", irq_o, 0);
    rd(2'd0, d); check("R1 mask", d, 8'h00);
    rd(2'd1, d); check("R1 flag", d, 8'h00);

    // R2 table
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr(2'd0, 8'(VEC_PR[v]));
      pulse(VEC_N[v]);
      check("R2 prescaled count", count_o, VEC_EXP[v]);
    end

    // R3: count is not writable
    rd(2'd3, d); check("R3 count low before", d, 8'h02);
    wr(2'd2, 8'h5A);
    wr(2'd3, 8'hA5);
    check("R3 count after writes", count_o, 2);
    rd(2'd2, d); check("R3 count high", d, 8'h00);

    // R8: write at 63 pulses accepted, second write ignored
    do_reset();
    pulse(63);
    wr(2'd0, 8'h01);
    rd(2'd0, d); check("R8 window edge accepted", d, 8'h01);
    wr(2'd0, 8'h03);
    rd(2'd0, d); check("R8 second write ignored", d, 8'h01);
    // R8: write after 64 pulses ignored
    do_reset();
    pulse(64);
    wr(2'd0, 8'h02);
    rd(2'd0, d); check("R8 late write ignored", d, 8'h00);
    pulse(8);
    check("R8 divide stays 1", count_o, 72);
    // R9: enable writable after lock
    wr(2'd0, 8'h80);
    rd(2'd0, d); check("R9 enable set after lock", d, 8'h80);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R9 enable cleared after lock", d, 8'h00);

    // R4 / R7: first rollover at divide-by-1
    do_reset();
    wr(2'd0, 8'h80);
    pulse(65535);
    check("R4 at top", count_o, 16'hFFFF);
    check("R7 no irq before wrap", irq_o, 0);
    pulse(1);
    check("R4 wrapped", count_o, 0);
    rd(2'd1, d); check("R4 flag set", d, 8'h80);
    check("R7 irq raised", irq_o, 1);
    // R5: zero in bit 7 has no effect
    wr(2'd1, 8'h7F);
    rd(2'd1, d); check("R5 write zero keeps flag", d, 8'h80);
    // R7 / R9: enable gates request
    wr(2'd0, 8'h00);
    check("R7 irq off with enable low", irq_o, 0);
    wr(2'd0, 8'h80);
    check("R7 irq back with enable high", irq_o, 1);

    // R6: rollover and clear in the same cycle
    pulse(65535);
    check("R6 at top again", count_o, 16'hFFFF);
    @(negedge clk_i);
    eclk_en_i = 1'b1; wr_en_i = 1'b1; addr_i = 2'd1; wdata_i = 8'h80;
    @(negedge clk_i);
    eclk_en_i = 1'b0; wr_en_i = 1'b0;
    check("R6 count wrapped", count_o, 0);
    rd(2'd1, d); check("R6 set wins", d, 8'h80);

    // R5: clear
    wr(2'd1, 8'h80);
    rd(2'd1, d); check("R5 flag cleared", d, 8'h00);
    check("R7 irq dropped", irq_o, 0);
    wr(2'd1, 8'hFF);
    wr(2'd1, 8'h00);
    rd(2'd1, d); check("R5 write never sets", d, 8'h00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule